// File: doc/BRIEF.md
# Virtual Function Routing ID Decoder

This block sits on the configuration request path of a physical function that owns a set of virtual functions on the same bus. Each incoming request carries an 8-bit function routing ID. The block decides whether that ID belongs to one of the currently live virtual functions. If it does, the block returns the function's index. It also flags when the identity word of the header must read back as the all-ones placeholder.

The virtual functions sit in an arithmetic progression. The first one is at the physical function's routing ID plus a programmed offset, and each later one adds a programmed stride. The block finds a match arithmetically, by subtracting the first ID and dividing by the stride. It then gates the match with the enable bit and with the programmed and maximum function counts.

A static checker watches the programmed parameters all the time. It raises a configuration error when the progression would run past the 8-bit routing space or when the offset is zero. While that error is raised, no request is reported as a hit. All results are registered and appear one cycle after the request.

Top module: `vf_rid_decoder`

## Requirements
- R1: With a valid configuration, enable set and at least one function counted, a request whose ID equals PF ID + offset hits with index 0.
- R2: A request whose ID equals PF ID + offset + k × stride, with stride nonzero, hits with index k, provided k is below both the enabled count and the maximum count.
- R3: A request whose ID is below the first VF ID, or whose distance from the first VF ID is not a multiple of the stride, does not hit. When there is no hit, the index output is 0.
- R4: A hit needs the enable input at 1 and an index strictly below the enabled count and below the maximum count. Any other request does not hit.
- R5: With stride 0, only the first VF ID hits, with index 0. Every other ID misses.
- R6: The configuration error output is 1 when the maximum count is nonzero and PF ID + offset + (maximum count − 1) × stride is 256 or more. The sum is evaluated without truncation. A last VF ID of exactly 255 is not an error.
- R7: The configuration error output is 1 whenever the offset is 0.
- R8: No hit is reported in any cycle in which the configuration error output is 1.
- R9: The ID-override output is 1 exactly when a request hits and its ID-register select input was 1. The ID value output is 16'hFFFF while the override is 1 and 16'h0000 otherwise.
- R10: Every output reflects the inputs present at the previous rising clock edge. The valid output equals the previous request-valid input. A cycle without a valid request produces no hit.
- R11: While the active-low reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pf_rid_i | input | RID_W | Routing ID of the physical function |
| vf_ofs_i | input | OFS_W | Offset from the PF ID to the first VF ID |
| vf_stride_i | input | STR_W | Distance between consecutive VF IDs |
| total_vfs_i | input | CNT_W | Maximum number of virtual functions |
| num_vfs_i | input | CNT_W | Number of virtual functions currently enabled |
| vf_en_i | input | 1 | Virtual function enable |
| req_valid_i | input | 1 | Request present this cycle |
| req_rid_i | input | RID_W | Routing ID targeted by the request |
| req_id_reg_i | input | 1 | Request reads the vendor/device identity word |
| vld_o | output | 1 | Registered request-valid |
| hit_o | output | 1 | Request targets a live virtual function |
| vf_idx_o | output | RID_W | Index of the hit function, 0 on a miss |
| id_ovr_o | output | 1 | Identity word must return the placeholder |
| id_val_o | output | 16 | Placeholder identity value, zero when not overriding |
| cfg_err_o | output | 1 | Static configuration error |

## Verification
On every cycle the assertions check the following properties: there is no hit while the configuration error is raised, there is no hit with enable low, a hit's index lies below the enabled count, a zero offset flags an error, the override is tied consistently to a hit and to the placeholder value, and valid follows the request by one cycle. The exact index arithmetic can only be shown by the bench's scenarios, which compare against a model that walks the progression. These scenarios cover stride-multiple versus off-progression IDs, the stride-zero single-function case, the 255 versus 256 overflow boundary including a large stride, and the count gating.

// File: rtl/vf_rid_pkg.sv
package vf_rid_pkg;
  localparam int unsigned ID_W = 16;
  typedef logic [ID_W-1:0] cfg_id_t;
  localparam cfg_id_t PLACEHOLDER_ID = 16'hFFFF;
  localparam cfg_id_t NULL_ID        = 16'h0000;

  typedef struct packed {
    logic vld;
    logic hit;
    logic ovr;
    logic err;
  } dec_flags_t;
endpackage

// File: rtl/vf_rid_divider.sv
// Unrolled restoring divider: one compare/subtract stage per dividend bit.
module vf_rid_divider #(
  parameter int unsigned DVD_W = 8,
  parameter int unsigned DSR_W = 16
) (
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DSR_W-1:0] dsr_i,
  output logic [DVD_W-1:0] quo_o,
  output logic             rem_zero_o
);
  localparam int unsigned PW = DSR_W + 1;

  logic [PW-1:0] part [DVD_W+1];
  logic [PW-1:0] dsr_x;

  assign dsr_x   = {1'b0, dsr_i};
  assign part[0] = '0;

  for (genvar s = 0; s < DVD_W; s++) begin : g_stage
    logic [PW-1:0] shf;
    logic [PW-1:0] sub;
    logic          ge;
    // partial remainder stays below the divisor, so its MSB is zero before the shift
    assign shf = (part[s] << 1) | PW'(dvd_i[DVD_W-1-s]);
    assign ge  = (shf >= dsr_x);
    assign sub = shf - dsr_x;
    assign quo_o[DVD_W-1-s] = ge;
    assign part[s+1] = ge ? sub : shf;
  end

  assign rem_zero_o = (part[DVD_W] == '0);
endmodule

// File: rtl/vf_rid_range_chk.sv
module vf_rid_range_chk #(
  parameter int unsigned RID_W = 8,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned STR_W = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned FW   = ((RID_W > OFS_W) ? RID_W : OFS_W) + 1,
  localparam int unsigned LW   = FW + CNT_W + STR_W
) (
  input  logic [RID_W-1:0] pf_rid_i,
  input  logic [OFS_W-1:0] vf_ofs_i,
  input  logic [STR_W-1:0] vf_stride_i,
  input  logic [CNT_W-1:0] total_vfs_i,
  output logic [FW-1:0]    first_o,
  output logic             cfg_err_o
);
  logic [LW-1:0] last_w;
  logic [LW-1:0] span_w;
  logic [LW-1:0] lim_w;
  logic          tot_nz;
  logic          ovf;

  assign first_o = FW'(pf_rid_i) + FW'(vf_ofs_i);
  assign tot_nz  = (total_vfs_i != '0);
  assign span_w  = LW'(total_vfs_i - CNT_W'(1)) * LW'(vf_stride_i);
  assign last_w  = LW'(first_o) + span_w;
  assign lim_w   = LW'(1) << RID_W;
  assign ovf     = tot_nz && (last_w >= lim_w);

  assign cfg_err_o = ovf || (vf_ofs_i == '0);
endmodule

// File: rtl/vf_rid_match.sv
module vf_rid_match #(
  parameter int unsigned RID_W = 8,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned STR_W = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned FW   = ((RID_W > OFS_W) ? RID_W : OFS_W) + 1,
  localparam int unsigned CW   = (CNT_W > RID_W) ? CNT_W : RID_W
) (
  input  logic [FW-1:0]    first_i,
  input  logic [RID_W-1:0] req_rid_i,
  input  logic [STR_W-1:0] vf_stride_i,
  input  logic [CNT_W-1:0] total_vfs_i,
  input  logic [CNT_W-1:0] num_vfs_i,
  input  logic             vf_en_i,
  output logic             hit_o,
  output logic [RID_W-1:0] idx_o
);
  logic [RID_W-1:0] diff;
  logic [RID_W-1:0] quo;
  logic             rem_zero;
  logic             above;
  logic             on_grid;
  logic [RID_W-1:0] idx_c;
  logic [CW-1:0]    idx_x;

  assign above = (FW'(req_rid_i) >= first_i);
  assign diff  = req_rid_i - first_i[RID_W-1:0];

  vf_rid_divider #(
    .DVD_W (RID_W),
    .DSR_W (STR_W)
  ) i_div (
    .dvd_i      (diff),
    .dsr_i      (vf_stride_i),
    .quo_o      (quo),
    .rem_zero_o (rem_zero)
  );

  always_comb begin
    if (vf_stride_i == '0) begin
      on_grid = (diff == '0);
      idx_c   = '0;
    end else begin
      on_grid = rem_zero;
      idx_c   = quo;
    end
  end

  assign idx_x = CW'(idx_c);
  assign hit_o = vf_en_i && above && on_grid &&
                 (idx_x < CW'(num_vfs_i)) && (idx_x < CW'(total_vfs_i));
  assign idx_o = hit_o ? idx_c : '0;
endmodule

// File: rtl/vf_rid_decoder.sv
module vf_rid_decoder
  import vf_rid_pkg::*;
#(
  parameter int unsigned RID_W = 8,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned STR_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RID_W-1:0] pf_rid_i,
  input  logic [OFS_W-1:0] vf_ofs_i,
  input  logic [STR_W-1:0] vf_stride_i,
  input  logic [CNT_W-1:0] total_vfs_i,
  input  logic [CNT_W-1:0] num_vfs_i,
  input  logic             vf_en_i,
  input  logic             req_valid_i,
  input  logic [RID_W-1:0] req_rid_i,
  input  logic             req_id_reg_i,
  output logic             vld_o,
  output logic             hit_o,
  output logic [RID_W-1:0] vf_idx_o,
  output logic             id_ovr_o,
  output logic [ID_W-1:0]  id_val_o,
  output logic             cfg_err_o
);
  localparam int unsigned FW = ((RID_W > OFS_W) ? RID_W : OFS_W) + 1;

  logic [FW-1:0]    first;
  logic             err_c;
  logic             match_c;
  logic [RID_W-1:0] idx_c;
  dec_flags_t       flg_d, flg_q;
  logic [RID_W-1:0] idx_d, idx_q;

  vf_rid_range_chk #(
    .RID_W (RID_W), .OFS_W (OFS_W), .STR_W (STR_W), .CNT_W (CNT_W)
  ) i_range (
    .pf_rid_i    (pf_rid_i),
    .vf_ofs_i    (vf_ofs_i),
    .vf_stride_i (vf_stride_i),
    .total_vfs_i (total_vfs_i),
    .first_o     (first),
    .cfg_err_o   (err_c)
  );

  vf_rid_match #(
    .RID_W (RID_W), .OFS_W (OFS_W), .STR_W (STR_W), .CNT_W (CNT_W)
  ) i_match (
    .first_i     (first),
    .req_rid_i   (req_rid_i),
    .vf_stride_i (vf_stride_i),
    .total_vfs_i (total_vfs_i),
    .num_vfs_i   (num_vfs_i),
    .vf_en_i     (vf_en_i),
    .hit_o       (match_c),
    .idx_o       (idx_c)
  );

  always_comb begin
    flg_d.vld = req_valid_i;
    flg_d.err = err_c;
    flg_d.hit = req_valid_i && !err_c && match_c;
    flg_d.ovr = flg_d.hit && req_id_reg_i;
    idx_d     = flg_d.hit ? idx_c : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
      idx_q <= '0;
    end else begin
      flg_q <= flg_d;
      idx_q <= idx_d;
    end
  end

  assign vld_o     = flg_q.vld;
  assign hit_o     = flg_q.hit;
  assign id_ovr_o  = flg_q.ovr;
  assign cfg_err_o = flg_q.err;
  assign vf_idx_o  = idx_q;
  assign id_val_o  = flg_q.ovr ? PLACEHOLDER_ID : NULL_ID;
endmodule

// File: rtl/vf_rid_decoder_chk.sv
module vf_rid_decoder_chk #(
  parameter int unsigned RID_W = 8,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned STR_W = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned CW   = (CNT_W > RID_W) ? CNT_W : RID_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [RID_W-1:0] pf_rid_i,
  input logic [OFS_W-1:0] vf_ofs_i,
  input logic [STR_W-1:0] vf_stride_i,
  input logic [CNT_W-1:0] total_vfs_i,
  input logic [CNT_W-1:0] num_vfs_i,
  input logic             vf_en_i,
  input logic             req_valid_i,
  input logic [RID_W-1:0] req_rid_i,
  input logic             req_id_reg_i,
  input logic             vld_o,
  input logic             hit_o,
  input logic [RID_W-1:0] vf_idx_o,
  input logic             id_ovr_o,
  input logic [15:0]      id_val_o,
  input logic             cfg_err_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r8_no_hit_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !hit_o);

  a_r10_hit_needs_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> vld_o);

  a_r10_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (vld_o == $past(req_valid_i)));

  a_r9_ovr_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_ovr_o |-> (hit_o && id_val_o == 16'hFFFF));

  a_r9_idle_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_ovr_o |-> (id_val_o == 16'h0000));

  a_r9_ovr_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && hit_o) |-> (id_ovr_o == $past(req_id_reg_i)));

  a_r7_zero_ofs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(vf_ofs_i) == '0) |-> cfg_err_o);

  a_r4_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(vf_en_i)) |-> !hit_o);

  a_r4_idx_below_num: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && hit_o) |-> (CW'(vf_idx_o) < CW'($past(num_vfs_i))));

  a_r3_idx_zero_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (vf_idx_o == '0));
endmodule

bind vf_rid_decoder vf_rid_decoder_chk #(
  .RID_W (RID_W), .OFS_W (OFS_W), .STR_W (STR_W), .CNT_W (CNT_W)
) i_chk (.*);

// File: tb/test_vf_rid_decoder.sv
module test_vf_rid_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pf_rid_i = '0;
  logic [15:0] vf_ofs_i = '0;
  logic [15:0] vf_stride_i = '0;
  logic [15:0] total_vfs_i = '0;
  logic [15:0] num_vfs_i = '0;
  logic        vf_en_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_rid_i = '0;
  logic        req_id_reg_i = 1'b0;
  logic        vld_o, hit_o, id_ovr_o, cfg_err_o;
  logic [7:0]  vf_idx_o;
  logic [15:0] id_val_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [27:0] exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;  // 50 MHz

  vf_rid_decoder i_vf_rid_decoder (.*);

  // {vld, hit, ovr, err, idx[7:0], id_val[15:0]}
  function automatic logic [27:0] model(logic v, logic [7:0] rid, logic idr);
    longint first, last;
    logic err, hit, ovr;
    logic [7:0] idx;
    first = longint'(pf_rid_i) + longint'(vf_ofs_i);
    last  = first + (longint'(total_vfs_i) - 1) * longint'(vf_stride_i);
    err   = (vf_ofs_i == 0) || (total_vfs_i != 0 && last >= 256);
    hit = 1'b0;
    idx = '0;
    if (v && !err && vf_en_i) begin
      for (int k = 0; k < 256; k++) begin
        if (!hit && first + longint'(k) * longint'(vf_stride_i) == longint'(rid) &&
            k < int'(num_vfs_i) && k < int'(total_vfs_i)) begin
          hit = 1'b1;
          idx = 8'(k);
        end
      end
    end
    ovr = hit && idr;
    return {v, hit, ovr, err, idx, ovr ? 16'hFFFF : 16'h0000};
  endfunction

  task automatic drive(input logic v, input logic [7:0] rid, input logic idr, input string tag);
    @(negedge clk_i);
    #1;
    req_valid_i  = v;
    req_rid_i    = rid;
    req_id_reg_i = idr;
    exp_q.push_back(model(v, rid, idr));
    tag_q.push_back(tag);
  endtask

  task automatic set_cfg(input logic [7:0] pf, input logic [15:0] ofs, input logic [15:0] str,
                         input logic [15:0] tot, input logic [15:0] num, input logic en,
                         input string tag);
    @(negedge clk_i);
    #1;
    pf_rid_i = pf; vf_ofs_i = ofs; vf_stride_i = str;
    total_vfs_i = tot; num_vfs_i = num; vf_en_i = en;
    req_valid_i = 1'b0;
    exp_q.push_back(model(1'b0, req_rid_i, req_id_reg_i));
    tag_q.push_back(tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (exp_q.size() > 0) begin
        logic [27:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {vld_o, hit_o, id_ovr_o, cfg_err_o, vf_idx_o, id_val_o};
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: actual vld=%b hit=%b ovr=%b err=%b idx=%0d id=%h expected vld=%b hit=%b ovr=%b err=%b idx=%0d id=%h",
                   t, a[27], a[26], a[25], a[24], a[23:16], a[15:0],
                   e[27], e[26], e[25], e[24], e[23:16], e[15:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: outputs held at zero in reset even with a hitting request present
    pf_rid_i = 8'h20; vf_ofs_i = 16'd4; vf_stride_i = 16'd2;
    total_vfs_i = 16'd8; num_vfs_i = 16'd8; vf_en_i = 1'b1;
    req_valid_i = 1'b1; req_rid_i = 8'h24; req_id_reg_i = 1'b1;
    repeat (3) @(negedge clk_i);
    n_chk++;
    if ({vld_o, hit_o, id_ovr_o, cfg_err_o, vf_idx_o, id_val_o} !== 28'h0) begin
      n_fail++;
      $display("FAIL R11: actual %h expected 0",
               {vld_o, hit_o, id_ovr_o, cfg_err_o, vf_idx_o, id_val_o});
    end
    req_valid_i = 1'b0;
    rst_ni = 1'b1;

    set_cfg(8'h20, 16'd4, 16'd2, 16'd8, 16'd8, 1'b1, "R10 cfg");
    drive(1'b1, 8'h24, 1'b0, "R1 first VF");
    drive(1'b1, 8'h26, 1'b0, "R2 second VF");
    drive(1'b1, 8'h32, 1'b0, "R2 last VF");
    drive(1'b1, 8'h34, 1'b0, "R4 beyond total");
    drive(1'b1, 8'h25, 1'b0, "R3 off grid");
    drive(1'b1, 8'h20, 1'b0, "R3 PF itself");
    drive(1'b1, 8'h23, 1'b0, "R3 below first");
    drive(1'b0, 8'h24, 1'b1, "R10 no valid");
    drive(1'b1, 8'h2A, 1'b1, "R9 override");

    set_cfg(8'h20, 16'd4, 16'd2, 16'd8, 16'd3, 1'b1, "R4 cfg");
    drive(1'b1, 8'h28, 1'b0, "R4 last enabled");
    drive(1'b1, 8'h2A, 1'b1, "R4 above NumVFs");
    set_cfg(8'h20, 16'd4, 16'd2, 16'd8, 16'd8, 1'b0, "R4 cfg");
    drive(1'b1, 8'h24, 1'b0, "R4 disabled");

    set_cfg(8'h30, 16'd1, 16'd0, 16'd1, 16'd1, 1'b1, "R5 cfg");
    drive(1'b1, 8'h31, 1'b1, "R5 single VF");
    drive(1'b1, 8'h32, 1'b0, "R5 stride zero miss");

    set_cfg(8'h05, 16'd3, 16'd3, 16'd20, 16'd20, 1'b1, "R2 cfg");
    for (int k = 0; k < 24; k++) drive(1'b1, 8'(8 + k * 2), k[0], "R2 sweep stride 3");

    set_cfg(8'hF0, 16'd8, 16'd1, 16'd8, 16'd8, 1'b1, "R6 cfg edge");
    drive(1'b1, 8'hFF, 1'b0, "R6 last at 255");
    set_cfg(8'hF0, 16'd8, 16'd1, 16'd9, 16'd9, 1'b1, "R6 cfg over");
    drive(1'b1, 8'hF8, 1'b1, "R8 no hit on error");
    set_cfg(8'h00, 16'd1, 16'h0100, 16'd2, 16'd2, 1'b1, "R6 big stride");
    drive(1'b1, 8'h01, 1'b0, "R8 big stride err");
    set_cfg(8'h00, 16'd1, 16'h0100, 16'd1, 16'd1, 1'b1, "R6 big stride single");
    drive(1'b1, 8'h01, 1'b0, "R6 single VF no err");
    set_cfg(8'h00, 16'h0200, 16'd1, 16'd0, 16'd0, 1'b1, "R6 zero total");
    drive(1'b1, 8'h10, 1'b0, "R6 zero total no hit");
    set_cfg(8'h40, 16'd0, 16'd1, 16'd4, 16'd4, 1'b1, "R7 zero offset");
    drive(1'b1, 8'h40, 1'b1, "R7 zero offset no hit");

    repeat (3) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule